// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Arbiter

This block tracks the receive and transmit interrupt sources of a two-channel serial controller and drives one shared interrupt line. Each channel has four state bits: a pending bit and an in-service bit for receive, and the same pair for transmit. From these the block builds a pending-summary byte that software reads back, a modified interrupt vector that names the source most recently raised or cleared, and a four-bit in-service mask.

The surrounding serial logic drives single-cycle event pulses. The events are: a received byte arrived, the received data register was read, the transmit data register was written, and the transmit buffer is empty. Two commands also arrive as pulses: clear the transmit interrupt, and reset the highest in-service source. The enable fields from the control registers are level inputs. All state changes on one rising clock edge. A receive source that is in service holds back a newly raised transmit source from going in service. Clearing one source re-raises the other if it is still pending. A select input switches the vector between a low-bit form and a high-bit form.

Throughout, index 0 of every two-bit channel bus is channel A and index 1 is channel B.

Top module: `dual_serial_irq_arb`

## Requirements
- R1: The synchronous reset `rst` clears every pending and in-service bit. After the first clock edge with `rst` high, `irq` is 0, `pend_sum` is 0x00, `in_svc` is 0 and `vector` is 0x06.
- R2: A receive-arrival pulse on a channel sets that channel's receive pending bit and its receive in-service bit. `in_svc` bit 3 is A receive and bit 1 is B receive. The pulse also sets `pend_sum` bit 5 for A or bit 2 for B, and loads the receive vector code. All outputs show the new state one edge after the pulse.
- R3: `irq` is registered. It is the OR over both channels of three terms: transmit enabled and transmit pending; receive mode 01 or 10 and receive pending; break enabled and break status. Receive modes 00 and 11 never raise `irq`.
- R4: A buffer-empty pulse sets transmit pending. If no receive interrupt is in service on that channel, it also sets transmit in-service and loads the transmit vector code. `in_svc` bit 2 is A transmit and bit 0 is B transmit. The summary transmit bit (bit 4 for A, bit 1 for B) is set only when transmit interrupts are enabled.
- R5: A transmit-data write clears transmit pending, so `irq` falls. It leaves the vector, the summary byte and the in-service bits unchanged.
- R6: A data-register read clears receive pending, receive in-service and the summary receive bit, and loads the no-interrupt code. If transmit is still pending, the read then re-raises it as in R4.
- R7: The clear-transmit command clears transmit pending, transmit in-service and the summary transmit bit, and loads the no-interrupt code. If receive is still pending, the command then re-raises it as in R2.
- R8: The reset-in-service command first checks receive. If receive in-service is set, the command clears it and re-raises a still-pending transmit source. If receive in-service is clear, the command clears transmit in-service instead.
- R9: With `vec_hi` = 0 the vector codes are: no interrupt 0x06, A receive 0x0C, B receive 0x04, A transmit 0x08, B transmit 0x00. With `vec_hi` = 1 they are 0x60, 0x30, 0x20 and 0x10, and B transmit stays 0x00. If both channels update the vector in the same cycle, channel B's code is kept.
- R10: For each channel, break enable AND break status drives `irq` and a summary bit: bit 3 for A, bit 0 for B. Both are sampled at the clock edge. Summary bits 7 and 6 are always 0.
- R11: When a set event and a clear event for the same source arrive in the same cycle, the set wins.
- R12: While receive is in service on a channel, a buffer-empty pulse there makes transmit pending but changes neither the vector, nor transmit in-service, nor the summary transmit bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_arrive | input | 2 | Received-byte pulse per channel |
| data_read | input | 2 | Data-register read pulse per channel |
| tx_write | input | 2 | Transmit-data write pulse per channel |
| tx_empty | input | 2 | Transmit-buffer-empty pulse per channel |
| clr_tx_cmd | input | 2 | Clear-transmit-interrupt command pulse |
| rst_ius_cmd | input | 2 | Reset-highest-in-service command pulse |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode_a | input | 2 | Receive interrupt mode, channel A |
| rx_mode_b | input | 2 | Receive interrupt mode, channel B |
| brk_ie | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break status per channel |
| vec_hi | input | 1 | Selects the high-bit vector form |
| irq | output | 1 | Shared interrupt request |
| pend_sum | output | 8 | Pending-summary byte |
| vector | output | VEC_W | Modified interrupt vector |
| in_svc | output | 4 | In-service mask {A rx, A tx, B rx, B tx} |

## Verification
The bench aims at the ordering rules. It raises a transmit source while receive is in service and expects the vector to stay on the receive code. A design that ignored the blocking would jump to the transmit code and mark transmit in service too early. It clears each source while the other is still pending; a design missing the re-raise would leave the vector at 0x06 with nothing in service. It issues the reset-in-service command twice in a row, which tells apart a design that clears both in-service bits at once or clears them in the wrong order. It also drives a set and a clear of the same source in one cycle, where a design that lets the clear win would drop the pending bit and `irq`.

// File: rtl/sia_pkg.sv
package sia_pkg;

   // kind of vector update requested by one channel in one cycle
   typedef enum logic [1:0] {
      VK_NONE = 2'd0,
      VK_RX   = 2'd1,
      VK_TX   = 2'd2
   } vkind_e;

   // per-channel interrupt state
   typedef struct packed {
      logic prx;   // receive pending
      logic irx;   // receive in service
      logic ptx;   // transmit pending
      logic itx;   // transmit in service
      logic srx;   // summary receive bit
      logic stx;   // summary transmit bit
   } chan_st_t;

   // state plus the vector update produced while stepping through events
   typedef struct packed {
      chan_st_t st;
      logic     vw;
      vkind_e   vk;
   } step_t;

   // vector codes, low and high form
   localparam logic [7:0] VC_NONE_LO = 8'h06;
   localparam logic [7:0] VC_NONE_HI = 8'h60;
   localparam logic [7:0] VC_RXA_LO  = 8'h0C;
   localparam logic [7:0] VC_RXA_HI  = 8'h30;
   localparam logic [7:0] VC_RXB_LO  = 8'h04;
   localparam logic [7:0] VC_RXB_HI  = 8'h20;
   localparam logic [7:0] VC_TXA_LO  = 8'h08;
   localparam logic [7:0] VC_TXA_HI  = 8'h10;
   localparam logic [7:0] VC_TXB     = 8'h00;

   function automatic logic rx_mode_on(input logic [1:0] m);
      return (m == 2'b01) || (m == 2'b10);
   endfunction

   function automatic step_t raise_rx(input step_t s);
      step_t r;
      r        = s;
      r.st.prx = 1'b1;
      r.st.irx = 1'b1;
      r.st.srx = 1'b1;
      r.vw     = 1'b1;
      r.vk     = VK_RX;
      return r;
   endfunction

   function automatic step_t raise_tx(input step_t s, input logic ie);
      step_t r;
      r        = s;
      r.st.ptx = 1'b1;
      if (!r.st.irx) begin
         r.st.itx = 1'b1;
         if (ie) r.st.stx = 1'b1;
         r.vw = 1'b1;
         r.vk = VK_TX;
      end
      return r;
   endfunction

endpackage

// File: rtl/sia_chan.sv
module sia_chan
   import sia_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     ev_rx_arrive,
   input  logic     ev_data_read,
   input  logic     ev_tx_write,
   input  logic     ev_tx_empty,
   input  logic     cmd_clr_tx,
   input  logic     cmd_rst_ius,
   input  logic     tx_ie,
   output chan_st_t st_q,
   output chan_st_t st_n,
   output logic     vec_wr,
   output vkind_e   vec_kind
);

   // events are applied clears first and sets last, so a set wins
   always_comb begin
      step_t s;
      s.st = st_q;
      s.vw = 1'b0;
      s.vk = VK_NONE;
      if (ev_tx_write) s.st.ptx = 1'b0;
      if (cmd_clr_tx) begin
         s.st.ptx = 1'b0;
         s.st.itx = 1'b0;
         s.st.stx = 1'b0;
         s.vw     = 1'b1;
         s.vk     = VK_NONE;
         if (s.st.prx) s = raise_rx(s);
      end
      if (ev_data_read) begin
         s.st.prx = 1'b0;
         s.st.irx = 1'b0;
         s.st.srx = 1'b0;
         s.vw     = 1'b1;
         s.vk     = VK_NONE;
         if (s.st.ptx) s = raise_tx(s, tx_ie);
      end
      if (cmd_rst_ius) begin
         if (s.st.irx) begin
            s.st.irx = 1'b0;
            if (s.st.ptx) s = raise_tx(s, tx_ie);
         end else begin
            s.st.itx = 1'b0;
         end
      end
      if (ev_tx_empty)  s = raise_tx(s, tx_ie);
      if (ev_rx_arrive) s = raise_rx(s);
      st_n     = s.st;
      vec_wr   = s.vw;
      vec_kind = s.vk;
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= '0;
      else     st_q <= st_n;
   end

   // R2
   rx_set_chk: assert property (@(posedge clk) disable iff (rst)
      ev_rx_arrive |=> (st_q.prx && st_q.irx && st_q.srx));

   // R11
   tx_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      ev_tx_empty |=> st_q.ptx);

   // R7
   clr_tx_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_clr_tx && !ev_tx_empty) |=> (!st_q.ptx && !st_q.itx));

   // R5
   tx_write_chk: assert property (@(posedge clk) disable iff (rst)
      (ev_tx_write && !ev_tx_empty) |=> !st_q.ptx);

endmodule

// File: rtl/sia_vec_enc.sv
module sia_vec_enc
   import sia_pkg::*;
#(
   parameter int VEC_W = 8,
   parameter bit IS_B  = 1'b0
) (
   input  vkind_e           kind,
   input  logic             hi,
   output logic [VEC_W-1:0] code
);

   logic [7:0] raw;

   generate
      if (IS_B) begin : g_b
         always_comb begin
            case (kind)
               VK_RX:   raw = hi ? VC_RXB_HI : VC_RXB_LO;
               VK_TX:   raw = VC_TXB;
               default: raw = hi ? VC_NONE_HI : VC_NONE_LO;
            endcase
         end
      end else begin : g_a
         always_comb begin
            case (kind)
               VK_RX:   raw = hi ? VC_RXA_HI : VC_RXA_LO;
               VK_TX:   raw = hi ? VC_TXA_HI : VC_TXA_LO;
               default: raw = hi ? VC_NONE_HI : VC_NONE_LO;
            endcase
         end
      end
   endgenerate

   assign code = VEC_W'(raw);

endmodule

// File: rtl/dual_serial_irq_arb.sv
module dual_serial_irq_arb
   import sia_pkg::*;
#(
   parameter int VEC_W         = 8,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       rx_arrive,
   input  logic [1:0]       data_read,
   input  logic [1:0]       tx_write,
   input  logic [1:0]       tx_empty,
   input  logic [1:0]       clr_tx_cmd,
   input  logic [1:0]       rst_ius_cmd,
   input  logic [1:0]       tx_ie,
   input  logic [1:0]       rx_mode_a,
   input  logic [1:0]       rx_mode_b,
   input  logic [1:0]       brk_ie,
   input  logic [1:0]       brk_stat,
   input  logic             vec_hi,
   output logic             irq,
   output logic [7:0]       pend_sum,
   output logic [VEC_W-1:0] vector,
   output logic [3:0]       in_svc
);

   localparam int NCH = 2;

   generate
      if (VEC_W < 7) begin : g_bad_width
         $error("VEC_W must hold the seven-bit vector codes");
      end
   endgenerate

   chan_st_t [NCH-1:0] st_q;
   chan_st_t [NCH-1:0] st_n;
   logic     [NCH-1:0] vw;
   vkind_e             vk     [NCH];
   logic [VEC_W-1:0]   code   [NCH];
   logic [1:0]         rmode  [NCH];
   logic [NCH-1:0]     term_n;
   logic [NCH-1:0]     term_q;
   logic [NCH-1:0]     brk_on;

   assign rmode[0] = rx_mode_a;
   assign rmode[1] = rx_mode_b;

   genvar ch;
   generate
      for (ch = 0; ch < NCH; ch++) begin : g_ch
         sia_chan u_chan (
            .clk          (clk),
            .rst          (rst),
            .ev_rx_arrive (rx_arrive[ch]),
            .ev_data_read (data_read[ch]),
            .ev_tx_write  (tx_write[ch]),
            .ev_tx_empty  (tx_empty[ch]),
            .cmd_clr_tx   (clr_tx_cmd[ch]),
            .cmd_rst_ius  (rst_ius_cmd[ch]),
            .tx_ie        (tx_ie[ch]),
            .st_q         (st_q[ch]),
            .st_n         (st_n[ch]),
            .vec_wr       (vw[ch]),
            .vec_kind     (vk[ch])
         );

         sia_vec_enc #(.VEC_W(VEC_W), .IS_B(ch == 1)) u_enc (
            .kind (vk[ch]),
            .hi   (vec_hi),
            .code (code[ch])
         );

         assign brk_on[ch] = brk_ie[ch] & brk_stat[ch];
         assign term_n[ch] = (tx_ie[ch] & st_n[ch].ptx)
                           | (rx_mode_on(rmode[ch]) & st_n[ch].prx)
                           | brk_on[ch];
         assign term_q[ch] = (tx_ie[ch] & st_q[ch].ptx)
                           | (rx_mode_on(rmode[ch]) & st_q[ch].prx)
                           | brk_on[ch];
      end
   endgenerate

   // channel B is stepped after channel A, so its vector write is kept
   logic [VEC_W-1:0] vector_q;
   logic [VEC_W-1:0] vector_d;
   logic [7:0]       sum_q;

   always_comb begin
      vector_d = vector_q;
      if (vw[0]) vector_d = code[0];
      if (vw[1]) vector_d = code[1];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vector_q <= VEC_W'(VC_NONE_LO);
         sum_q    <= 8'h00;
      end else begin
         vector_q <= vector_d;
         sum_q    <= {2'b00, st_n[0].srx, st_n[0].stx, brk_on[0],
                             st_n[1].srx, st_n[1].stx, brk_on[1]};
      end
   end

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (rst) irq_q <= 1'b0;
            else     irq_q <= |term_n;
         end
         assign irq = irq_q;

         // R3
         irq_source_chk: assert property (@(posedge clk) disable iff (rst)
            irq |-> ((st_q[0].prx | st_q[0].ptx | st_q[1].prx | st_q[1].ptx)
                     || $past(|brk_on)));
      end else begin : g_irq_comb
         assign irq = !rst && (|term_q);
      end
   endgenerate

   assign vector   = vector_q;
   assign pend_sum = sum_q;
   assign in_svc   = {st_q[0].irx, st_q[0].itx, st_q[1].irx, st_q[1].itx};

   // R9
   vec_legal_chk: assert property (@(posedge clk) disable iff (rst)
      (vector == VEC_W'(VC_NONE_LO)) || (vector == VEC_W'(VC_NONE_HI)) ||
      (vector == VEC_W'(VC_RXA_LO))  || (vector == VEC_W'(VC_RXA_HI))  ||
      (vector == VEC_W'(VC_RXB_LO))  || (vector == VEC_W'(VC_RXB_HI))  ||
      (vector == VEC_W'(VC_TXA_LO))  || (vector == VEC_W'(VC_TXA_HI))  ||
      (vector == VEC_W'(VC_TXB)));

   // R10
   sum_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
      pend_sum[7:6] == 2'b00);

   // R12
   rx_blocks_tx_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q[0].irx && tx_empty[0] && !data_read[0] && !rst_ius_cmd[0]
       && !clr_tx_cmd[0] && !rx_arrive[0] && !vw[1]) |=> $stable(vector));

endmodule

// File: tb/dual_serial_irq_arb_tb.sv
`timescale 1ns/1ps
module dual_serial_irq_arb_tb;

   logic       clk = 1'b0;
   logic       rst;
   logic [1:0] rx_arrive, data_read, tx_write, tx_empty, clr_tx_cmd, rst_ius_cmd;
   logic [1:0] tx_ie, rx_mode_a, rx_mode_b, brk_ie, brk_stat;
   logic       vec_hi;
   logic       irq;
   logic [7:0] pend_sum;
   logic [7:0] vector;
   logic [3:0] in_svc;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   dual_serial_irq_arb u_dut (
      .clk(clk), .rst(rst),
      .rx_arrive(rx_arrive), .data_read(data_read), .tx_write(tx_write),
      .tx_empty(tx_empty), .clr_tx_cmd(clr_tx_cmd), .rst_ius_cmd(rst_ius_cmd),
      .tx_ie(tx_ie), .rx_mode_a(rx_mode_a), .rx_mode_b(rx_mode_b),
      .brk_ie(brk_ie), .brk_stat(brk_stat), .vec_hi(vec_hi),
      .irq(irq), .pend_sum(pend_sum), .vector(vector), .in_svc(in_svc)
   );

   task automatic check8(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=0x%02h expected=0x%02h", tag, what, act, exp);
      end
   endtask

   task automatic expect_all(input string tag, input logic ei,
                             input logic [7:0] es, input logic [7:0] ev,
                             input logic [3:0] eu);
      check8(tag, "irq", {7'd0, irq}, {7'd0, ei});
      check8(tag, "pend_sum", pend_sum, es);
      check8(tag, "vector", vector, ev);
      check8(tag, "in_svc", {4'd0, in_svc}, {4'd0, eu});
   endtask

   // one clock edge; pulses set before the call are dropped afterwards
   task automatic go();
      @(negedge clk);
      rx_arrive = 0; data_read = 0; tx_write = 0; tx_empty = 0;
      clr_tx_cmd = 0; rst_ius_cmd = 0;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      go(); go();
      expect_all("R1 reset", 0, 8'h00, 8'h06, 4'h0);
      rst = 1'b0;
      go();
      expect_all("R1 after release", 0, 8'h00, 8'h06, 4'h0);
   endtask

   task automatic t_rx_basic();
      rx_mode_a = 2'b01;
      rx_arrive[0] = 1; go();
      expect_all("R2 rx A arrive", 1, 8'h20, 8'h0C, 4'h8);
      data_read[0] = 1; go();
      expect_all("R6 rx A read", 0, 8'h00, 8'h06, 4'h0);
   endtask

   task automatic t_rx_modes();
      rx_mode_b = 2'b11;
      rx_arrive[1] = 1; go();
      expect_all("R3 mode 11 no irq", 0, 8'h04, 8'h04, 4'h2);
      rx_mode_b = 2'b00; go();
      check8("R3 mode 00", "irq", {7'd0, irq}, 8'h00);
      rx_mode_b = 2'b10; go();
      check8("R3 mode 10", "irq", {7'd0, irq}, 8'h01);
      data_read[1] = 1; go();
      expect_all("R6 rx B read", 0, 8'h00, 8'h06, 4'h0);
   endtask

   task automatic t_tx_enable();
      tx_ie[1] = 0;
      tx_empty[1] = 1; go();
      expect_all("R4 tx B disabled", 0, 8'h00, 8'h00, 4'h1);
      clr_tx_cmd[1] = 1; go();
      expect_all("R7 clr tx B", 0, 8'h00, 8'h06, 4'h0);
      tx_ie[1] = 1;
      tx_empty[1] = 1; go();
      expect_all("R4 tx B enabled", 1, 8'h02, 8'h00, 4'h1);
      tx_write[1] = 1; go();
      expect_all("R5 tx B write", 0, 8'h02, 8'h00, 4'h1);
      clr_tx_cmd[1] = 1; go();
      expect_all("R7 clr tx B again", 0, 8'h00, 8'h06, 4'h0);
   endtask

   task automatic t_rx_blocks_tx();
      tx_ie[0] = 1; rx_mode_a = 2'b10;
      rx_arrive[0] = 1; go();
      expect_all("R2 rx A", 1, 8'h20, 8'h0C, 4'h8);
      tx_empty[0] = 1; go();
      expect_all("R12 tx held by rx", 1, 8'h20, 8'h0C, 4'h8);
      data_read[0] = 1; go();
      expect_all("R6 read re-raises tx", 1, 8'h10, 8'h08, 4'h4);
      clr_tx_cmd[0] = 1; go();
      expect_all("R7 clr tx A", 0, 8'h00, 8'h06, 4'h0);
   endtask

   task automatic t_clr_tx_reraise();
      rx_arrive[0] = 1; go();
      tx_empty[0] = 1; go();
      clr_tx_cmd[0] = 1; go();
      expect_all("R7 clr tx re-raises rx", 1, 8'h20, 8'h0C, 4'h8);
      data_read[0] = 1; go();
      expect_all("R6 read A clean", 0, 8'h00, 8'h06, 4'h0);
   endtask

   task automatic t_rst_ius();
      rx_arrive[0] = 1; go();
      tx_empty[0] = 1; go();
      expect_all("R12 tx held", 1, 8'h20, 8'h0C, 4'h8);
      rst_ius_cmd[0] = 1; go();
      expect_all("R8 first reset-ius", 1, 8'h30, 8'h08, 4'h4);
      rst_ius_cmd[0] = 1; go();
      expect_all("R8 second reset-ius", 1, 8'h30, 8'h08, 4'h0);
      data_read[0] = 1; go();
      expect_all("R6 read with tx pending", 1, 8'h10, 8'h08, 4'h4);
      clr_tx_cmd[0] = 1; go();
      expect_all("R7 clean", 0, 8'h00, 8'h06, 4'h0);
   endtask

   task automatic t_vec_high();
      vec_hi = 1;
      rx_arrive[1] = 1; go();
      check8("R9 hi rx B", "vector", vector, 8'h20);
      data_read[1] = 1; go();
      check8("R9 hi none", "vector", vector, 8'h60);
      tx_empty[1] = 1; go();
      check8("R9 hi tx B", "vector", vector, 8'h00);
      clr_tx_cmd[1] = 1; go();
      check8("R9 hi none B", "vector", vector, 8'h60);
      rx_arrive[0] = 1; go();
      check8("R9 hi rx A", "vector", vector, 8'h30);
      data_read[0] = 1; go();
      tx_empty[0] = 1; go();
      check8("R9 hi tx A", "vector", vector, 8'h10);
      clr_tx_cmd[0] = 1; go();
      check8("R9 hi none A", "vector", vector, 8'h60);
      rx_arrive = 2'b11; go();
      check8("R9 both channels B wins", "vector", vector, 8'h20);
      data_read = 2'b11; go();
      vec_hi = 0;
      expect_all("R9 clean", 0, 8'h00, 8'h60, 4'h0);
   endtask

   task automatic t_break();
      brk_ie[0] = 1; brk_stat[0] = 0; go();
      expect_all("R10 A enabled no status", 0, 8'h00, 8'h60, 4'h0);
      brk_stat[0] = 1; go();
      expect_all("R10 A break", 1, 8'h08, 8'h60, 4'h0);
      brk_ie[0] = 0; go();
      expect_all("R10 A disabled", 0, 8'h00, 8'h60, 4'h0);
      brk_stat[0] = 0;
      brk_ie[1] = 1; brk_stat[1] = 1; go();
      expect_all("R10 B break", 1, 8'h01, 8'h60, 4'h0);
      brk_ie[1] = 0; brk_stat[1] = 0; go();
      check8("R10 B cleared", "irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_set_wins();
      rx_arrive[0] = 1; data_read[0] = 1; go();
      expect_all("R11 rx set and read", 1, 8'h20, 8'h0C, 4'h8);
      data_read[0] = 1; go();
      tx_empty[1] = 1; tx_write[1] = 1; go();
      expect_all("R11 tx empty and write", 1, 8'h02, 8'h00, 4'h1);
      tx_empty[1] = 1; clr_tx_cmd[1] = 1; go();
      expect_all("R11 tx empty and clear", 1, 8'h02, 8'h00, 4'h1);
      clr_tx_cmd[1] = 1; go();
      expect_all("R11 clean", 0, 8'h00, 8'h06, 4'h0);
   endtask

   task automatic t_midrun_reset();
      rx_arrive[0] = 1; tx_empty[1] = 1; go();
      check8("R1 pre-reset", "irq", {7'd0, irq}, 8'h01);
      rst = 1; go();
      expect_all("R1 mid-run reset", 0, 8'h00, 8'h06, 4'h0);
      rst = 0; go();
      expect_all("R1 mid-run release", 0, 8'h00, 8'h06, 4'h0);
   endtask

   initial begin
      rst = 1; vec_hi = 0;
      rx_arrive = 0; data_read = 0; tx_write = 0; tx_empty = 0;
      clr_tx_cmd = 0; rst_ius_cmd = 0;
      tx_ie = 0; rx_mode_a = 0; rx_mode_b = 0; brk_ie = 0; brk_stat = 0;
      t_reset();
      t_rx_basic();
      t_rx_modes();
      t_tx_enable();
      t_rx_blocks_tx();
      t_clr_tx_reraise();
      t_rst_ius();
      t_vec_high();
      t_break();
      t_set_wins();
      t_midrun_reset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule